// File: doc/BRIEF.md
# Double-Buffered DAC Code Register with Segmented Switch Decode

This block is the digital front end of a parallel-input multiplying digital-to-analog converter, modelled in a single system clock domain. A code word arrives on a parallel bus. An active-low write strobe captures it into a staging register. A load strobe then moves the staged word into the conversion register, which sets the analog output. Because the load strobe is a separate input, several converters can be staged one at a time and then updated together with one shared load pulse.

The two strobes are asynchronous to the system clock. Each is passed through a synchronizer chain. The register behaviour is then evaluated once per clock from the synchronized levels, so the design uses no latches. An asynchronous active-low reset clears both registers. A static strap selects whether reset goes to zero scale or to midscale. The reset is asserted at once and released in step with the clock.

The conversion register feeds the switch-drive outputs. Its top four bits become a 15-wide thermometer of equal-weight segment enables. The remaining bits drive the binary ladder section directly. The code width is a parameter and can be 16 or 14 bits.

Top module: `dac_fe_top`

## Requirements
- R1: While `rst_n` is low, both registers are forced to their reset value at once, without waiting for a clock edge, and this overrides any strobe activity. With `mid_sel` = 0 the reset value is zero scale (all bits 0).
- R2: With `mid_sel` = 1 the reset value is midscale: the top code bit is 1 and all other bits are 0 (0x8000 for 16 bits).
- R3: With `wr_n` low and `ld` low, the staging register follows `din` and `dac_code` holds its value.
- R4: With `wr_n` high and `ld` high, `dac_code` takes the staging register contents, and later changes on `din` have no effect.
- R5: With `wr_n` low and `ld` high, both registers are transparent, and `dac_code` follows `din`.
- R6: With `wr_n` high and `ld` low, neither register changes. A later transfer therefore delivers the word staged before this state, not the bus value seen during it.
- R7: When `wr_n` and `ld` are driven together as one low-going pulse, the word on `din` is staged while the pulse is low, with `dac_code` unchanged. It reaches `dac_code` once the pulse returns high.
- R8: `seg_en[i]` is 1 exactly when i is less than the value of the top four bits of `dac_code`. The enables fill from index 0 upward: a value of 0 gives no enables and a value of 15 gives all 15.
- R9: `bin_drive` equals the low W-4 bits of `dac_code`.
- R10: A change on `wr_n` or `ld` reaches `dac_code` on the third rising clock edge after it, with the default synchronizer depth of 2. The first two edges leave the output unchanged.
- R11: With W = 14, the midscale reset value is 0x2000, the thermometer is decoded from bits 13..10, and `bin_drive` is 10 bits wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mid_sel | input | 1 | Static reset-value strap: 0 gives zero scale, 1 gives midscale |
| wr_n | input | 1 | Active-low write strobe (asynchronous) |
| ld | input | 1 | Load strobe, active high (asynchronous) |
| din | input | W | Parallel code bus |
| dac_code | output | W | Conversion register contents |
| seg_en | output | 15 | Thermometer enables for the equal-weight segments |
| bin_drive | output | W-4 | Binary ladder switch drive |

## Verification
A wrong value in the conversion register shows on `dac_code`, `seg_en` and `bin_drive` in the same cycle. A wrong staging register stays hidden until the next transfer. For that reason the bench follows every hold or ignored-bus case with a transfer, so that a corrupted staged word is brought out to the ports. A synchronizer that is too short or too long shifts the update by one clock. The latency case samples `dac_code` on each of the three edges after a strobe change, which catches such a shift.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int SEG_MSBS  = 4;
  localparam int SEG_COUNT = (1 << SEG_MSBS) - 1;

  // Operation decoded from the synchronized {wr_n, ld} levels
  typedef enum logic [1:0] {
    OP_CAPTURE  = 2'b00,
    OP_PASS     = 2'b01,
    OP_HOLD     = 2'b10,
    OP_TRANSFER = 2'b11
  } ctrl_op_e;
endpackage

// File: rtl/dacfe_rst_sync.sv
module dacfe_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic arst_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign arst_n = chain_q[STAGES-1];
endmodule

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
  parameter int          N       = 2,
  parameter int          STAGES  = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  genvar b;
  generate
    for (b = 0; b < N; b++) begin : g_bit
      logic [STAGES-1:0] stg_q;
      logic [STAGES-1:0] stg_d;

      always_comb begin
        stg_d = {stg_q[STAGES-2:0], d[b]};
      end

      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
          stg_q <= {STAGES{RST_VAL[b]}};
        end else begin
          stg_q <= stg_d;
        end
      end

      assign q[b] = stg_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         mid_sel,
  input  logic         wr_n_s,
  input  logic         ld_s,
  input  logic [W-1:0] din,
  output logic [W-1:0] dac_q
);
  localparam logic [W-1:0] MID_CODE = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] stage_q;
  logic [W-1:0] stage_d;
  logic [W-1:0] dac_d;
  logic         stage_en;
  logic         dac_en;
  logic [W-1:0] rst_code;
  ctrl_op_e     op;

  assign rst_code = mid_sel ? MID_CODE : '0;

  // Next-state: clock enables and data selects per operation
  always_comb begin
    op       = ctrl_op_e'({wr_n_s, ld_s});
    stage_en = 1'b0;
    dac_en   = 1'b0;
    stage_d  = stage_q;
    dac_d    = dac_q;
    case (op)
      OP_CAPTURE: begin
        stage_en = 1'b1;
        stage_d  = din;
      end
      OP_PASS: begin
        stage_en = 1'b1;
        dac_en   = 1'b1;
        stage_d  = din;
        dac_d    = din;
      end
      OP_TRANSFER: begin
        dac_en = 1'b1;
        dac_d  = stage_q;
      end
      default: begin
        stage_en = 1'b0;
        dac_en   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= rst_code;
    end else if (stage_en) begin
      stage_q <= stage_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      dac_q <= rst_code;
    end else if (dac_en) begin
      dac_q <= dac_d;
    end
  end

  // R3: staging captures the bus while write is active
  a_r3_stage_capture: assert property (@(posedge clk) disable iff (!arst_n)
    !wr_n_s |=> stage_q == $past(din));
  // R3 and R6: with load low the conversion register keeps its value
  a_r3_dac_hold: assert property (@(posedge clk) disable iff (!arst_n)
    !ld_s |=> $stable(dac_q));
  // R4 and R6: with write inactive the staged word is kept
  a_r4_stage_hold: assert property (@(posedge clk) disable iff (!arst_n)
    wr_n_s |=> $stable(stage_q));
  // R4: transfer moves the staged word across
  a_r4_transfer: assert property (@(posedge clk) disable iff (!arst_n)
    (wr_n_s && ld_s) |=> dac_q == $past(stage_q));
  // R5: both registers transparent
  a_r5_pass: assert property (@(posedge clk) disable iff (!arst_n)
    (!wr_n_s && ld_s) |=> dac_q == $past(din));
  // R1 and R2: first cycle after reset release shows the strapped value
  a_r1_reset_value: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(arst_n) |-> (dac_q == rst_code && stage_q == rst_code));
endmodule

// File: rtl/dacfe_segdec.sv
module dacfe_segdec
  import dacfe_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0]        code,
  output logic [SEG_COUNT-1:0] seg_en,
  output logic [W-SEG_MSBS-1:0] bin_drive
);
  localparam int BIN_W = W - SEG_MSBS;

  logic [SEG_MSBS-1:0] top_val;

  assign top_val   = code[W-1 -: SEG_MSBS];
  assign bin_drive = code[BIN_W-1:0];

  genvar i;
  generate
    for (i = 0; i < SEG_COUNT; i++) begin : g_seg
      assign seg_en[i] = (top_val > SEG_MSBS'(i));
    end
  endgenerate
endmodule

// File: rtl/dac_fe_top.sv
module dac_fe_top
  import dacfe_pkg::*;
#(
  parameter int W           = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mid_sel,
  input  logic                  wr_n,
  input  logic                  ld,
  input  logic [W-1:0]          din,
  output logic [W-1:0]          dac_code,
  output logic [SEG_COUNT-1:0]  seg_en,
  output logic [W-SEG_MSBS-1:0] bin_drive
);
  logic       arst_n;
  logic [1:0] ctrl_s;

  dacfe_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .arst_n (arst_n)
  );

  // {wr_n, ld} idle in the hold state while reset is applied
  dacfe_sync #(.N(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b10)) u_ctrl_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      ({wr_n, ld}),
    .q      (ctrl_s)
  );

  dacfe_regs #(.W(W)) u_regs (
    .clk     (clk),
    .arst_n  (arst_n),
    .mid_sel (mid_sel),
    .wr_n_s  (ctrl_s[1]),
    .ld_s    (ctrl_s[0]),
    .din     (din),
    .dac_q   (dac_code)
  );

  dacfe_segdec #(.W(W)) u_segdec (
    .code      (dac_code),
    .seg_en    (seg_en),
    .bin_drive (bin_drive)
  );

  logic [SEG_COUNT:0] seg_ext;
  assign seg_ext = {1'b0, seg_en};

  // R8: number of enables matches the top field of the register
  a_r8_count: assert property (@(posedge clk) disable iff (!arst_n)
    $countones(seg_en) == int'(dac_code[W-1 -: SEG_MSBS]));
  // R8: enables are contiguous from index 0
  a_r8_fill: assert property (@(posedge clk) disable iff (!arst_n)
    ((seg_ext + {{SEG_COUNT{1'b0}}, 1'b1}) & seg_ext) == '0);
  // R9: binary section carries the low register bits
  a_r9_binary: assert property (@(posedge clk) disable iff (!arst_n)
    bin_drive == dac_code[W-SEG_MSBS-1:0]);
endmodule

// File: tb/dac_fe_top_tb_top.sv
module dac_fe_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        mid_sel;
  logic        wr_n;
  logic        ld;
  logic [15:0] din;
  logic [15:0] dac_code;
  logic [14:0] seg_en;
  logic [11:0] bin_drive;
  logic [13:0] dac14;
  logic [14:0] seg14;
  logic [9:0]  bin14;

  int n_checks = 0;
  int n_fail   = 0;

  typedef struct {
    string       req;
    logic [15:0] code;
  } sb_item_t;
  sb_item_t sb_q[$];

  dac_fe_top #(.W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .mid_sel(mid_sel), .wr_n(wr_n), .ld(ld),
    .din(din), .dac_code(dac_code), .seg_en(seg_en), .bin_drive(bin_drive)
  );

  dac_fe_top #(.W(14)) dut14_i (
    .clk(clk), .rst_n(rst_n), .mid_sel(1'b1), .wr_n(wr_n), .ld(ld),
    .din(din[13:0]), .dac_code(dac14), .seg_en(seg14), .bin_drive(bin14)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [42:0] model16(logic [15:0] c);
    logic [14:0] s;
    for (int i = 0; i < 15; i++) s[i] = (i < int'(c[15:12]));
    return {c, s, c[11:0]};
  endfunction

  function automatic logic [38:0] model14(logic [13:0] c);
    logic [14:0] s;
    for (int i = 0; i < 15; i++) s[i] = (i < int'(c[13:10]));
    return {c, s, c[9:0]};
  endfunction

  task automatic check(string req, logic [42:0] act, logic [42:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check14(string req, logic [13:0] c);
    check(req, {4'h0, dac14, seg14, bin14}, {4'h0, model14(c)});
  endtask

  // Driver side
  task automatic drive(bit w, bit l, logic [15:0] d);
    @(negedge clk);
    #1;
    wr_n = w;
    ld   = l;
    din  = d;
  endtask

  task automatic expect_next(string req, logic [15:0] code);
    @(posedge clk);
    sb_q.push_back('{req, code});
  endtask

  task automatic settle_expect(string req, logic [15:0] code);
    repeat (4) @(posedge clk);
    expect_next(req, code);
  endtask

  // Monitor side
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      check(it.req, {dac_code, seg_en, bin_drive}, model16(it.code));
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual running expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b1; mid_sel = 1'b0; wr_n = 1'b1; ld = 1'b0; din = '0;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", {dac_code, seg_en, bin_drive}, model16(16'h0000));
    check14("R11", 14'h2000);
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);

    drive(1'b0, 1'b0, 16'h1234); settle_expect("R3", 16'h0000);
    drive(1'b1, 1'b1, 16'h1234); settle_expect("R4", 16'h1234);
    drive(1'b1, 1'b1, 16'hFFFF); settle_expect("R4", 16'h1234);
    drive(1'b1, 1'b0, 16'hABCD); settle_expect("R6", 16'h1234);
    drive(1'b1, 1'b1, 16'hABCD); settle_expect("R6", 16'h1234);

    drive(1'b0, 1'b1, 16'h5A5A); settle_expect("R5", 16'h5A5A);
    drive(1'b0, 1'b1, 16'hC3C3); settle_expect("R5", 16'hC3C3);
    drive(1'b0, 1'b1, 16'h0000); settle_expect("R8 R9", 16'h0000);
    drive(1'b0, 1'b1, 16'hFFFF); settle_expect("R8 R9", 16'hFFFF);
    drive(1'b0, 1'b1, 16'h8000); settle_expect("R8 R9", 16'h8000);
    drive(1'b0, 1'b1, 16'h1001); settle_expect("R8 R9", 16'h1001);

    // R7: tied strobes, low-going pulse
    drive(1'b1, 1'b1, 16'h1001); settle_expect("R7", 16'h1001);
    drive(1'b0, 1'b0, 16'h7000); settle_expect("R7", 16'h1001);
    drive(1'b1, 1'b1, 16'h7000); settle_expect("R7", 16'h7000);
    drive(1'b1, 1'b1, 16'h1111); settle_expect("R7", 16'h7000);

    // R10: update lands on the third edge
    drive(1'b0, 1'b0, 16'h0F0F); settle_expect("R10", 16'h7000);
    drive(1'b1, 1'b1, 16'h0F0F);
    expect_next("R10", 16'h7000);
    expect_next("R10", 16'h7000);
    expect_next("R10", 16'h0F0F);
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    check14("R11", 14'h0F0F);

    // R2 with R1 override of transparent mode
    drive(1'b0, 1'b1, 16'hFFFF);
    mid_sel = 1'b1;
    rst_n   = 1'b0;
    #1;
    check("R2", {dac_code, seg_en, bin_drive}, model16(16'h8000));
    check14("R11", 14'h2000);
    repeat (6) @(negedge clk);
    check("R1", {dac_code, seg_en, bin_drive}, model16(16'h8000));
    #1 rst_n = 1'b1;
    repeat (8) @(posedge clk);
    expect_next("R5", 16'hFFFF);
    while (sb_q.size() > 0) @(posedge clk);
    @(negedge clk);
    check14("R11", 14'h3FFF);
    finish_run();
  end
endmodule